// File: doc/BRIEF.md
# Serial Frame Mode Interpreter

This block sits behind the serial receiver of a codec. It decides what each received 16-bit frame means. Two mode bits, taken from a control register that lives outside the block, select one of three modes:

- **Program mode:** every frame is a control word.
- **Normal data mode:** every frame is converter data.
- **Mixed mode:** the top bit of each frame says whether it is control or converter data.

In the two data modes the block counts frame syncs against a device-count field, so that only this device's slot in a cascade is taken. A taken frame either loads the output-converter (DAC) register or issues a control write.

Entering normal data mode locks the block in that mode until reset. While locked, no control word gets through.

Two control-register bits switch on the analog and digital loop-back paths. The block ensures that these bits can be cleared only in mixed mode. It also marks outgoing input-converter (ADC) words as data while mixed mode is active.

Mode decode uses two inputs:

- `modeData` low: program mode, whatever the value of `modeMixed`.
- `modeData` high with `modeMixed` low: normal data mode.
- Both high: mixed mode.

A control word selects its target register in bits [13:11]. Select value 4 is the loop-back register, which holds the analog enable in bit 0 and the digital enable in bit 1.

Top module: `frame_mode_interp`

## Requirements
- R1: After reset, `dacLoad` and `ctrlWr` are 0, and `dacValue` and `ctrlWord` are 0.
- R2: In program mode, each frame produces a one-cycle `ctrlWr` in the cycle after `frameValid`, with `ctrlWord` equal to the frame (subject to R9). `dacLoad` stays 0.
- R3: In normal data mode, frame syncs are counted from 1. The sync whose count equals `devCount` produces a one-cycle `dacLoad` in the next cycle, with `dacValue` equal to the frame unchanged. The count then wraps back to 1. The other frames produce no output strobe. The count is held at its start value while in program mode.
- R4: A `devCount` of 0 stands for a cascade of eight, so only every eighth frame is taken.
- R5: In mixed mode, a taken frame with bit 15 = 0 loads `dacValue` with bits 14:0 of the frame shifted up one place, so that bit 0 is 0.
- R6: In mixed mode, a taken frame with bit 15 = 1 produces `ctrlWr` with `ctrlWord` equal to the frame. Frames of either kind advance the slot count.
- R7: Once normal data mode has been decoded, the block treats every later frame as normal data until reset, whatever the mode inputs do, and never raises `ctrlWr`.
- R8: `adcOut` equals `adcIn` with bit 15 forced to 0 while mixed mode is active, and equals `adcIn` otherwise.
- R9: In program mode, a control write to select 4 keeps bit 0 set if `albOn` is 1 and bit 1 set if `dlbOn` is 1. In mixed mode the word passes unchanged, so the loop-back bits can be cleared. Words to other selects are never altered.
- R10: `dacLoad` and `ctrlWr` are never high together, and each is high only in the cycle after a `frameValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Frame sync: a received frame is present this cycle |
| frameWord | input | 16 | Received frame |
| modeData | input | 1 | Data-mode bit of the mode register |
| modeMixed | input | 1 | Mixed-mode bit of the mode register |
| devCount | input | 3 | Cascade length (0 means 8) |
| albOn | input | 1 | Current analog loop-back enable |
| dlbOn | input | 1 | Current digital loop-back enable |
| adcIn | input | 16 | Input-converter word before tagging |
| dacLoad | output | 1 | Output-converter register load strobe |
| dacValue | output | 16 | Output-converter register value |
| ctrlWr | output | 1 | Control write strobe |
| ctrlWord | output | 16 | Control word to write |
| adcOut | output | 16 | Tagged input-converter word |

## Verification
The bench walks a cascade of three through two full rounds, to catch a counter that is off by one. Such a counter would load on the second or fourth frame, or would fail to wrap.

It sets a count of 0 and expects the eighth frame to be taken. A design that reads 0 literally would take nothing, or every frame.

After normal data mode has been entered, the bench flips the mode inputs back to program mode. A block without the lock would then emit a control write instead of loading the converter.

Loop-back writes that try to clear the enables are sent in program mode and again in mixed mode. A missing guard shows up as a cleared bit in program mode, and an over-eager guard shows up as a stuck bit in mixed mode.

// File: rtl/fmi_pkg.sv
package fmi_pkg;

  typedef enum logic [1:0] {
    MODE_PROGRAM = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_MIXED   = 2'd2
  } fmiMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDac;    // load converter register this cycle
    logic packMixed;  // pack 15-bit payload left-justified
    logic writeCtrl;  // issue control write this cycle
    logic guardLb;    // keep loop-back bits that are set
    logic tagAdc;     // clear MSB of outgoing ADC word
  } fmiStrobe_t;

endpackage

// File: rtl/fmi_ctrl.sv
module fmi_ctrl
  import fmi_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameValid,
  input  logic             frameMsb,
  input  logic             modeData,
  input  logic             modeMixed,
  input  logic [CNT_W-1:0] devCount,
  output fmiStrobe_t       strb,
  output logic             locked
);

  localparam int SLOTS = 1 << CNT_W;
  localparam logic [CNT_W:0] FULL_COUNT = SLOTS[CNT_W:0];

  logic             lockQ;
  logic [CNT_W-1:0] cntQ;
  fmiMode_e         decMode;
  fmiMode_e         effMode;
  logic [CNT_W:0]   effCount;
  logic [CNT_W:0]   nextCnt;
  logic             slotHit;

  // raw mode decode from the two register bits
  always_comb begin
    if (!modeData)      decMode = MODE_PROGRAM;
    else if (modeMixed) decMode = MODE_MIXED;
    else                decMode = MODE_NORMAL;
  end

  // once locked, normal data mode wins regardless of inputs
  assign effMode  = lockQ ? MODE_NORMAL : decMode;
  assign effCount = (devCount == '0) ? FULL_COUNT : {1'b0, devCount};
  assign nextCnt  = {1'b0, cntQ} + 1'b1;
  assign slotHit  = (nextCnt >= effCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      cntQ  <= '0;
    end else begin
      if (effMode == MODE_NORMAL) lockQ <= 1'b1;
      if (effMode == MODE_PROGRAM) begin
        cntQ <= '0;
      end else if (frameValid) begin
        cntQ <= slotHit ? '0 : nextCnt[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    strb = '0;
    strb.packMixed = (effMode == MODE_MIXED);
    strb.tagAdc    = (effMode == MODE_MIXED);
    strb.guardLb   = (effMode == MODE_PROGRAM);
    unique case (effMode)
      MODE_PROGRAM: strb.writeCtrl = frameValid;
      MODE_NORMAL:  strb.loadDac   = frameValid && slotHit;
      MODE_MIXED: begin
        strb.loadDac   = frameValid && slotHit && !frameMsb;
        strb.writeCtrl = frameValid && slotHit &&  frameMsb;
      end
      default: strb = '0;
    endcase
  end

  assign locked = lockQ;

  // R7: lock is sticky until reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  // R3: slot counter parked while in program mode
  a_r3_hold_in_program: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == MODE_PROGRAM) |=> (cntQ == '0));

  // R10: never both strobes for the same frame
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.loadDac && strb.writeCtrl));

endmodule

// File: rtl/fmi_datapath.sv
module fmi_datapath
  import fmi_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SEL_LSB = 11,
  parameter int SEL_W   = 3,
  parameter int LB_SEL  = 4,
  parameter int ALB_BIT = 0,
  parameter int DLB_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmiStrobe_t        strb,
  input  logic [WORD_W-1:0] frameWord,
  input  logic              albOn,
  input  logic              dlbOn,
  input  logic [WORD_W-1:0] adcIn,
  output logic              dacLoad,
  output logic [WORD_W-1:0] dacValue,
  output logic              ctrlWr,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [WORD_W-1:0] adcOut
);

  localparam logic [SEL_W-1:0] LB_CODE = LB_SEL[SEL_W-1:0];

  logic [WORD_W-1:0] dacNext;
  logic [WORD_W-1:0] ctrlNext;
  logic              isLbSel;

  assign isLbSel = (frameWord[SEL_LSB +: SEL_W] == LB_CODE);

  // mixed frames carry 15 payload bits; shift up, zero LSB
  assign dacNext = strb.packMixed ? {frameWord[WORD_W-2:0], 1'b0} : frameWord;

  always_comb begin
    ctrlNext = frameWord;
    if (strb.guardLb && isLbSel) begin
      ctrlNext[ALB_BIT] = frameWord[ALB_BIT] | albOn;
      ctrlNext[DLB_BIT] = frameWord[DLB_BIT] | dlbOn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dacLoad  <= 1'b0;
      ctrlWr   <= 1'b0;
      dacValue <= '0;
      ctrlWord <= '0;
    end else begin
      dacLoad <= strb.loadDac;
      ctrlWr  <= strb.writeCtrl;
      if (strb.loadDac)   dacValue <= dacNext;
      if (strb.writeCtrl) ctrlWord <= ctrlNext;
    end
  end

  assign adcOut = strb.tagAdc ? {1'b0, adcIn[WORD_W-2:0]} : adcIn;

  // R5: packed mixed data always lands with LSB clear
  a_r5_mixed_lsb: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadDac && strb.packMixed) |=> (dacLoad && !dacValue[0]));

  // R9: a set analog loop-back bit survives a program-mode write
  a_r9_alb_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeCtrl && strb.guardLb && isLbSel && albOn) |=> ctrlWord[ALB_BIT]);

  // R9: same for digital loop-back
  a_r9_dlb_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeCtrl && strb.guardLb && isLbSel && dlbOn) |=> ctrlWord[DLB_BIT]);

endmodule

// File: rtl/frame_mode_interp.sv
module frame_mode_interp
  import fmi_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [WORD_W-1:0] frameWord,
  input  logic              modeData,
  input  logic              modeMixed,
  input  logic [CNT_W-1:0]  devCount,
  input  logic              albOn,
  input  logic              dlbOn,
  input  logic [WORD_W-1:0] adcIn,
  output logic              dacLoad,
  output logic [WORD_W-1:0] dacValue,
  output logic              ctrlWr,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [WORD_W-1:0] adcOut
);

  fmiStrobe_t strb;
  logic       locked;

  fmi_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .frameMsb   (frameWord[WORD_W-1]),
    .modeData   (modeData),
    .modeMixed  (modeMixed),
    .devCount   (devCount),
    .strb       (strb),
    .locked     (locked)
  );

  fmi_datapath #(.WORD_W(WORD_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .frameWord (frameWord),
    .albOn     (albOn),
    .dlbOn     (dlbOn),
    .adcIn     (adcIn),
    .dacLoad   (dacLoad),
    .dacValue  (dacValue),
    .ctrlWr    (ctrlWr),
    .ctrlWord  (ctrlWord),
    .adcOut    (adcOut)
  );

  // R10: outputs exclusive and only after a frame
  a_r10_out_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(dacLoad && ctrlWr));

  a_r10_dac_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dacLoad) |-> $past(frameValid));

  a_r10_ctrl_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlWr) |-> $past(frameValid));

  // R7: no control write once locked
  a_r7_locked_no_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> !ctrlWr);

endmodule

// File: tb/sim_frame_mode_interp.sv
module sim_frame_mode_interp;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameValid;
  logic [15:0] frameWord;
  logic        modeData, modeMixed;
  logic [2:0]  devCount;
  logic        albOn, dlbOn;
  logic [15:0] adcIn;
  logic        dacLoad, ctrlWr;
  logic [15:0] dacValue, ctrlWord, adcOut;

  int totalCnt = 0;
  int passCnt  = 0;

  always #10 clk = ~clk; // 50 MHz

  frame_mode_interp u0 (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameWord(frameWord),
    .modeData(modeData), .modeMixed(modeMixed), .devCount(devCount),
    .albOn(albOn), .dlbOn(dlbOn), .adcIn(adcIn),
    .dacLoad(dacLoad), .dacValue(dacValue), .ctrlWr(ctrlWr),
    .ctrlWord(ctrlWord), .adcOut(adcOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; frameValid = 1'b0; frameWord = '0;
    modeData = 1'b0; modeMixed = 1'b0; devCount = 3'd1;
    albOn = 1'b0; dlbOn = 1'b0; adcIn = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // drive one frame; outputs are sampled on the following negedge
  task automatic sendFrame(input logic [15:0] w);
    @(negedge clk);
    frameValid = 1'b1; frameWord = w;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 dacLoad", {15'd0, dacLoad}, 16'd0);
    chk("R1 ctrlWr", {15'd0, ctrlWr}, 16'd0);
    chk("R1 dacValue", dacValue, 16'h0000);
    chk("R1 ctrlWord", ctrlWord, 16'h0000);
  endtask

  task automatic testProgram();
    doReset();
    sendFrame(16'h1855);
    chk("R2 ctrlWr", {15'd0, ctrlWr}, 16'd1);
    chk("R2 ctrlWord", ctrlWord, 16'h1855);
    chk("R2 no dacLoad", {15'd0, dacLoad}, 16'd0);
    @(negedge clk);
    chk("R10 ctrlWr pulse", {15'd0, ctrlWr}, 16'd0);
  endtask

  task automatic testCascade();
    doReset();
    modeData = 1'b1; devCount = 3'd3;
    for (int i = 1; i <= 6; i++) begin
      sendFrame(16'h1000 + 16'(i));
      chk("R3 slot load", {15'd0, dacLoad}, (i % 3 == 0) ? 16'd1 : 16'd0);
      chk("R3 no ctrl", {15'd0, ctrlWr}, 16'd0);
    end
    chk("R3 dacValue", dacValue, 16'h1006);
  endtask

  task automatic testCountZero();
    doReset();
    modeData = 1'b1; devCount = 3'd0;
    for (int i = 1; i <= 8; i++) begin
      sendFrame(16'hA500 + 16'(i));
      chk("R4 eighth slot", {15'd0, dacLoad}, (i == 8) ? 16'd1 : 16'd0);
    end
    chk("R4 dacValue", dacValue, 16'hA508);
  endtask

  task automatic testMixed();
    doReset();
    modeData = 1'b1; modeMixed = 1'b1;
    sendFrame(16'h4321);
    chk("R5 load", {15'd0, dacLoad}, 16'd1);
    chk("R5 packed", dacValue, 16'h8642);
    sendFrame(16'h7FFF);
    chk("R5 packed full", dacValue, 16'hFFFE);
    sendFrame(16'h9234);
    chk("R6 ctrlWr", {15'd0, ctrlWr}, 16'd1);
    chk("R6 ctrlWord", ctrlWord, 16'h9234);
    chk("R6 no dac", {15'd0, dacLoad}, 16'd0);
    // cascade of two: control frame in slot 1 is skipped, slot 2 taken
    devCount = 3'd2;
    sendFrame(16'h8111);
    chk("R6 foreign slot skipped", {15'd0, ctrlWr}, 16'd0);
    sendFrame(16'h8222);
    chk("R6 own slot", ctrlWord, 16'h8222);
  endtask

  task automatic testAdcTag();
    doReset();
    adcIn = 16'hFFFF;
    #1;
    chk("R8 program untouched", adcOut, 16'hFFFF);
    modeData = 1'b1; modeMixed = 1'b1;
    #1;
    chk("R8 mixed tagged", adcOut, 16'h7FFF);
  endtask

  task automatic testLoopback();
    doReset();
    albOn = 1'b1;
    sendFrame(16'h2000);
    chk("R9 alb kept", ctrlWord, 16'h2001);
    dlbOn = 1'b1;
    sendFrame(16'h2000);
    chk("R9 both kept", ctrlWord, 16'h2003);
    sendFrame(16'h1800);
    chk("R9 other select untouched", ctrlWord, 16'h1800);
    modeData = 1'b1; modeMixed = 1'b1;
    sendFrame(16'hA000);
    chk("R9 mixed clears", ctrlWord, 16'hA000);
  endtask

  task automatic testLock();
    doReset();
    modeData = 1'b1;
    sendFrame(16'h0BEE);
    chk("R7 normal load", dacValue, 16'h0BEE);
    modeData = 1'b0;
    sendFrame(16'h1234);
    chk("R7 still data", {15'd0, dacLoad}, 16'd1);
    chk("R7 no ctrl", {15'd0, ctrlWr}, 16'd0);
    chk("R7 unpacked", dacValue, 16'h1234);
    modeData = 1'b1; modeMixed = 1'b1;
    sendFrame(16'h8F0F);
    chk("R7 mixed ignored", dacValue, 16'h8F0F);
    chk("R7 no ctrl mixed", {15'd0, ctrlWr}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    totalCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    rstN = 1'b0; frameValid = 1'b0; frameWord = '0;
    modeData = 1'b0; modeMixed = 1'b0; devCount = 3'd1;
    albOn = 1'b0; dlbOn = 1'b0; adcIn = '0;
    testReset();
    testProgram();
    testCascade();
    testCountZero();
    testMixed();
    testAdcTag();
    testLoopback();
    testLock();
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

endmodule